// File: doc/BRIEF.md
# Bang-Bang Integral Path Accumulator

This block forms the digital integral branch of a bang-bang phase-locked loop. It runs on the divided feedback clock. On every edge it takes a one-bit lead/lag decision and moves a wide running total either up or down by a programmable gain. When the total wraps past the top of its range, the block emits a one-cycle increment request. When it wraps past the bottom, it emits a one-cycle decrement request. A separate coarse capacitor controller consumes these requests. The wrapped remainder stays in the total and keeps steering the fine path.

The whole running total is presented on every cycle to a downstream requantizer. The gain word comes in through a plain strobe-and-data load port. A stored copy of the gain is used for stepping, so one step never sees a mix of old and new gain bits.

Top module: `bbint_accum`

## Requirements
- R1: After reset the total output reads 0x800000, both request pulses are low and the stored gain is zero, so the total holds at 0x800000 until a gain is loaded.
- R2: With lag_i = 1 the next total equals the present total plus the stored gain, zero-extended in its upper 8 bits.
- R3: With lag_i = 0 the next total equals the present total minus the zero-extended stored gain.
- R4: An add whose true result exceeds 0xFFFFFF leaves the total at that result modulo 2^24 and raises inc_o for exactly that one cycle.
- R5: A subtract whose true result is below zero leaves the total at that result modulo 2^24 and raises dec_o for exactly that one cycle.
- R6: inc_o and dec_o are never high together, and neither is high on a cycle whose step did not wrap.
- R7: A gain presented with gain_load_i = 1 is first used by the step at the edge after the one that captures it; the step at the capturing edge uses the previous gain.
- R8: Changes on gain_i while gain_load_i = 0 do not change the step size.
- R9: All 24 bits of the running total, not only the low 16, are visible on acc_o in the same cycle as the matching request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided feedback clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lag_i | input | 1 | Bang-bang decision: 1 adds the gain, 0 subtracts it |
| gain_load_i | input | 1 | Strobe that captures gain_i into the stored gain |
| gain_i | input | 16 | New integral gain value |
| acc_o | output | 24 | Running total sent to the fine requantizer |
| inc_o | output | 1 | One-cycle coarse step-up request on upper wrap |
| dec_o | output | 1 | One-cycle coarse step-down request on lower wrap |

## Verification
Two things can happen on the same edge: a gain load is captured, and the step taken there wraps the total and raises a request. The bench provokes this by stepping a reference model until it predicts that the next add will carry out. It then issues that add with the load strobe high and a very different gain. The check is that the total and inc_o follow the old gain on that edge and the new gain from the next edge on. A matching downward sequence tests dec_o in the same way.

// File: rtl/bbint_pkg.sv
package bbint_pkg;

  // Direction of one integration step, taken straight from the lag decision.
  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;

  // Wrap indications produced by one step.
  typedef struct packed {
    logic up_wrap;
    logic dn_wrap;
  } wrap_t;

  localparam int unsigned DEF_ACC_W  = 24;
  localparam int unsigned DEF_GAIN_W = 16;

endpackage

// File: rtl/bbint_rst_sync.sv
module bbint_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bbint_gain_reg.sv
module bbint_gain_reg #(
  parameter int unsigned GAIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [GAIN_W-1:0] gain_o
);

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;

  // Written-out enable: hold unless the strobe is present.
  always_comb begin
    gain_d = gain_q;
    if (load_i) begin
      gain_d = gain_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
    end else begin
      gain_q <= gain_d;
    end
  end

  assign gain_o = gain_q;

endmodule

// File: rtl/bbint_step_unit.sv
module bbint_step_unit
  import bbint_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned GAIN_W = 16
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  step_dir_e         dir_i,
  output logic [ACC_W-1:0]  acc_o,
  output wrap_t             wrap_o
);

  localparam int unsigned PAD_W = ACC_W - GAIN_W;

  logic [ACC_W-1:0] gain_ext;
  logic [ACC_W:0]   sum_w;
  logic [ACC_W:0]   dif_w;

  generate
    if (PAD_W == 0) begin : g_no_pad
      assign gain_ext = gain_i;
    end else begin : g_pad
      assign gain_ext = {{PAD_W{1'b0}}, gain_i};
    end
  endgenerate

  always_comb begin
    sum_w  = {1'b0, acc_i} + {1'b0, gain_ext};
    dif_w  = {1'b0, acc_i} - {1'b0, gain_ext};
    wrap_o = '0;
    if (dir_i == STEP_UP) begin
      acc_o          = sum_w[ACC_W-1:0];
      wrap_o.up_wrap = sum_w[ACC_W];
    end else begin
      acc_o          = dif_w[ACC_W-1:0];
      wrap_o.dn_wrap = dif_w[ACC_W];
    end
  end

endmodule

// File: rtl/bbint_accum.sv
module bbint_accum
  import bbint_pkg::*;
#(
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned GAIN_W     = DEF_GAIN_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lag_i,
  input  logic              gain_load_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              inc_o,
  output logic              dec_o
);

  localparam logic [ACC_W-1:0] MID_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

  logic              rst_sync_n;
  logic [GAIN_W-1:0] gain_cur;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;
  logic [ACC_W-1:0]  acc_step;
  wrap_t             wrap_step;
  logic              inc_q;
  logic              inc_d;
  logic              dec_q;
  logic              dec_d;

  bbint_rst_sync #(
    .STAGES (RST_STAGES)
  ) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  bbint_gain_reg #(
    .GAIN_W (GAIN_W)
  ) i_gain_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (gain_load_i),
    .gain_i (gain_i),
    .gain_o (gain_cur)
  );

  bbint_step_unit #(
    .ACC_W  (ACC_W),
    .GAIN_W (GAIN_W)
  ) i_step (
    .acc_i  (acc_q),
    .gain_i (gain_cur),
    .dir_i  (step_dir_e'(lag_i)),
    .acc_o  (acc_step),
    .wrap_o (wrap_step)
  );

  // Step every feedback cycle; request pulses last one cycle.
  always_comb begin
    acc_d = acc_step;
    inc_d = wrap_step.up_wrap;
    dec_d = wrap_step.dn_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= MID_SCALE;
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      inc_q <= inc_d;
      dec_q <= dec_d;
    end
  end

  assign acc_o = acc_q;
  assign inc_o = inc_q;
  assign dec_o = dec_q;

endmodule

// File: rtl/bbint_accum_chk.sv
module bbint_accum_chk #(
  parameter int unsigned ACC_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lag_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             inc_o,
  input logic             dec_o
);

  // R6: the two requests are mutually exclusive
  p_no_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && dec_o));

  // R4: an up request only follows an add and lands below the previous total
  p_inc_from_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> ($past(lag_i) && (acc_o < $past(acc_o))));

  // R5: a down request only follows a subtract and lands above the previous total
  p_dec_from_sub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o |-> (!$past(lag_i) && (acc_o > $past(acc_o))));

  // R2: an add that did not wrap never lowers the total
  p_add_rises_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lag_i) && !inc_o) |-> (acc_o >= $past(acc_o)));

  // R3: a subtract that did not wrap never raises the total
  p_sub_falls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(lag_i) && !dec_o) |-> (acc_o <= $past(acc_o)));

endmodule

bind bbint_accum bbint_accum_chk #(
  .ACC_W (ACC_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lag_i  (lag_i),
  .acc_o  (acc_o),
  .inc_o  (inc_o),
  .dec_o  (dec_o)
);

// File: tb/test_bbint_accum.sv
`timescale 1ns/1ps
module test_bbint_accum;

  typedef struct {
    logic [23:0] acc;
    logic        inc;
    logic        dec;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lag;
  logic        load;
  logic [15:0] gain;
  logic [23:0] acc_o;
  logic        inc_o;
  logic        dec_o;

  exp_t        sb_q[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  logic [23:0] m_acc;
  logic [15:0] m_gain;

  always #2 clk = ~clk;

  bbint_accum i_bbint_accum (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lag_i       (lag),
    .gain_load_i (load),
    .gain_i      (gain),
    .acc_o       (acc_o),
    .inc_o       (inc_o),
    .dec_o       (dec_o)
  );

  task automatic check(input string tag, input logic [23:0] a, input logic i,
                       input logic d, input logic [23:0] ea, input logic ei,
                       input logic ed);
    n_vec++;
    if (a !== ea || i !== ei || d !== ed) begin
      n_fail++;
      $display("FAIL %s: acc=%h inc=%b dec=%b expected acc=%h inc=%b dec=%b",
               tag, a, i, d, ea, ei, ed);
    end
    if (i === 1'b1 && d === 1'b1) begin
      n_fail++;
      $display("FAIL R6: inc=1 dec=1 expected at most one high");
    end
  endtask

  // Driver: apply one step at the falling edge, predict its result.
  task automatic step(input logic l, input logic ld, input logic [15:0] g,
                      input string tag);
    logic [24:0] t;
    exp_t        e;
    @(negedge clk);
    lag  = l;
    load = ld;
    gain = g;
    if (l) t = {1'b0, m_acc} + {9'b0, m_gain};
    else   t = {1'b0, m_acc} - {9'b0, m_gain};
    e.acc = t[23:0];
    e.inc = l & t[24];
    e.dec = ~l & t[24];
    e.tag = tag;
    m_acc = t[23:0];
    if (ld) m_gain = g;
    sb_q.push_back(e);
  endtask

  // Monitor: compare one cycle after each driven step.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, acc_o, inc_o, dec_o, e.acc, e.inc, e.dec);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lag   = 1'b0;
    load  = 1'b0;
    gain  = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_acc  = 24'h800000;
    m_gain = 16'h0;
    // R1: reset state, total held while the gain is zero
    check("R1", acc_o, inc_o, dec_o, 24'h800000, 1'b0, 1'b0);
  endtask

  function automatic bit add_wraps();
    logic [24:0] t;
    t = {1'b0, m_acc} + {9'b0, m_gain};
    return t[24];
  endfunction

  function automatic bit sub_wraps();
    logic [24:0] t;
    t = {1'b0, m_acc} - {9'b0, m_gain};
    return t[24];
  endfunction

  initial begin
    rst_n = 1'b0;
    lag   = 1'b0;
    load  = 1'b0;
    gain  = 16'h0;
    do_reset();

    step(1'b1, 1'b1, 16'h1234, "R7");  // load edge still uses gain 0
    step(1'b1, 1'b0, 16'h0000, "R2");
    step(1'b0, 1'b0, 16'h0000, "R3");
    step(1'b1, 1'b0, 16'hFFFF, "R8");  // gain_i moves without a load
    step(1'b0, 1'b0, 16'hA5A5, "R8");

    step(1'b1, 1'b1, 16'hFFFF, "R7");
    // climb until the upper wrap (R4, R9)
    for (int k = 0; k < 140; k++) step(1'b1, 1'b0, 16'h0, "R4");
    // fall until the lower wrap (R5)
    for (int k = 0; k < 300; k++) step(1'b0, 1'b0, 16'h0, "R5");
    // mixed decisions, full-width totals (R9, R6)
    for (int k = 0; k < 60; k++) step(k[0] ^ k[2], 1'b0, 16'h0, "R9");

    // gain load on the same edge as an upper wrap (R7 with R4)
    while (!add_wraps()) step(1'b1, 1'b0, 16'h0, "R4");
    step(1'b1, 1'b1, 16'h0001, "R7");
    step(1'b1, 1'b0, 16'h0, "R7");
    step(1'b1, 1'b0, 16'h0, "R7");

    // gain load on the same edge as a lower wrap (R7 with R5)
    step(1'b0, 1'b1, 16'hFFFF, "R7");
    while (!sub_wraps()) step(1'b0, 1'b0, 16'h0, "R5");
    step(1'b0, 1'b1, 16'h0003, "R7");
    step(1'b0, 1'b0, 16'h0, "R7");

    @(negedge clk);
    @(negedge clk);
    do_reset();
    step(1'b1, 1'b0, 16'h0, "R1");  // gain cleared by reset
    @(negedge clk);
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule